// File: doc/BRIEF.md
# Single-Multiplier Sequential FIR Filter

This block filters a stream of signed samples with a fixed set of tap weights. It uses one multiplier that is shared over all taps. Each accepted sample is written into a circular history buffer over the oldest entry. The control then walks the buffer backwards from that newest entry, and in step with it walks the weight table from index 0 upward. It forms one product per clock and adds it into a wide accumulator. When the last product of an output has been summed, the total is copied into a result register. That register holds steady until the next output is ready.

A producer offers a sample with `in_valid` and hands it over on any rising edge where `in_ready` is also high. `in_ready` is high while the filter is idle. It is also high during the final product cycle of a computation, so a new sample can follow the previous one every TAPS clocks. The highest input rate is therefore the clock rate divided by the tap count. Presenting a sample while `in_ready` is low is outside the protocol.

Top module: `mac_fir`

## Requirements
- R1: While reset is asserted and immediately after its release, `out_valid` is 0, `out_data` is 0 and `in_ready` is 1. The sample history is all zero.
- R2: Each output equals the sum over j = 0..TAPS-1 of w[j]·x[n-j]. Here x[n] is the sample just accepted, and history entries older than the first accepted sample count as zero.
- R3: The result is exact, with no wrap, for any sample and weight values. The output width is SW + CW + ceil(log2 TAPS) bits, two's complement.
- R4: `out_valid` is a single-cycle pulse. It is high in the cycle after clock edge A + TAPS + 2, where A is the edge on which the sample was accepted.
- R5: After an accept, `in_ready` is low for TAPS-1 cycles and high again in the final product cycle. With `in_valid` held high, successive accepts are exactly TAPS edges apart.
- R6: Between `out_valid` pulses, `out_data` holds the last result unchanged.
- R7: The history is circular. Only the latest TAPS samples contribute to an output. The write position advances by one per accept and wraps from TAPS-1 to 0, and the read position steps backward with a wrap from 0 to TAPS-1.
- R8: The weight at index i is ((i·2731 + 97) mod (2^CW − 15)) − (2^(CW−1) − 8), stored as a signed CW-bit value. An impulse of amplitude 1 after reset therefore yields w[0], w[1], … w[TAPS-1] on consecutive outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | A sample is offered on `in_data` |
| in_data | input | SW | Signed input sample |
| in_ready | output | 1 | Filter can take a sample on this edge |
| out_valid | output | 1 | One-cycle strobe, new result on `out_data` |
| out_data | output | SW+CW+clog2(TAPS) | Signed filter result, held between strobes |

## Verification
The bench builds the filter with its defaults: 31 taps, 16-bit samples and 16-bit weights. Because 31 is not a power of two, both pointers wrap at a non-binary boundary. The weights span almost the full signed 16-bit range. Samples chosen to match the sign of each weight at full scale drive the 37-bit sum close to its largest magnitude. The bench also holds `in_valid` high through a back-to-back run, which checks the TAPS-cycle accept spacing, including an accept that lands in the final product cycle.

// File: rtl/mac_fir_pkg.sv
package mac_fir_pkg;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } fir_state_e;

  // Width of an accumulator that can hold TAPS full-scale products without wrap.
  function automatic int unsigned acc_width(input int unsigned sw,
                                            input int unsigned cw,
                                            input int unsigned taps);
    return sw + cw + $clog2(taps);
  endfunction

  // Tap weight i: a spread of values over almost the full signed CW-bit range.
  function automatic longint tap_weight(input int unsigned idx,
                                        input int unsigned cw);
    longint modulus;
    longint centre;
    longint raw;
    modulus = (longint'(1) << cw) - 15;
    centre  = (longint'(1) << (cw - 1)) - 8;
    raw     = longint'(idx) * 2731 + 97;
    return (raw % modulus) - centre;
  endfunction

  // Step a ring index one place forward or backward over 0..n-1.
  function automatic int unsigned ring_step(input int unsigned p,
                                            input int unsigned n,
                                            input bit          fwd);
    if (fwd) return (p == n - 1) ? 0 : p + 1;
    return (p == 0) ? n - 1 : p - 1;
  endfunction

endpackage

// File: rtl/mac_fir_sample_ram.sv
module mac_fir_sample_ram #(
  parameter int TAPS = 31,
  parameter int SW   = 16,
  parameter int PW   = $clog2(TAPS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 we,
  input  logic [PW-1:0]        waddr,
  input  logic signed [SW-1:0] wdata,
  input  logic [PW-1:0]        raddr,
  output logic signed [SW-1:0] rdata
);

  logic signed [SW-1:0] mem_q [TAPS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < TAPS; i++) mem_q[i] <= '0;
    end else if (we) begin
      mem_q[waddr] <= wdata;
    end
  end

  // Asynchronous read: an entry overwritten at an edge is still read as its old value before that edge.
  assign rdata = mem_q[raddr];

endmodule

// File: rtl/mac_fir_coef_rom.sv
module mac_fir_coef_rom
  import mac_fir_pkg::*;
#(
  parameter int TAPS = 31,
  parameter int CW   = 16,
  parameter int PW   = $clog2(TAPS)
) (
  input  logic [PW-1:0]        addr,
  output logic signed [CW-1:0] coef
);

  localparam int SLOTS = 1 << PW;

  logic signed [CW-1:0] table_w [SLOTS];

  for (genvar g = 0; g < SLOTS; g++) begin : g_slot
    if (g < TAPS) begin : g_used
      assign table_w[g] = CW'(tap_weight(g, CW));
    end else begin : g_pad
      assign table_w[g] = '0;
    end
  end

  assign coef = table_w[addr];

endmodule

// File: rtl/mac_fir_ctrl.sv
module mac_fir_ctrl
  import mac_fir_pkg::*;
#(
  parameter int TAPS = 31,
  parameter int PW   = $clog2(TAPS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  output logic          accept,
  output logic [PW-1:0] wr_ptr,
  output logic [PW-1:0] rd_ptr,
  output logic [PW-1:0] tap_idx,
  output logic          mac_en,
  output logic          mac_first,
  output logic          mac_last
);

  localparam logic [PW-1:0] LAST_IDX = PW'(TAPS - 1);

  fir_state_e    state_q;
  logic [PW-1:0] tap_q;
  logic [PW-1:0] wr_q;
  logic [PW-1:0] rd_q;

  assign mac_en    = (state_q == ST_RUN);
  assign mac_last  = mac_en && (tap_q == LAST_IDX);
  assign mac_first = mac_en && (tap_q == '0);
  assign in_ready  = (state_q == ST_IDLE) || mac_last;
  assign accept    = in_valid && in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      tap_q   <= '0;
      wr_q    <= '0;
      rd_q    <= '0;
    end else if (accept) begin
      state_q <= ST_RUN;
      tap_q   <= '0;
      rd_q    <= wr_q;
      wr_q    <= PW'(ring_step(int'(wr_q), TAPS, 1'b1));
    end else if (mac_en) begin
      rd_q <= PW'(ring_step(int'(rd_q), TAPS, 1'b0));
      if (mac_last) begin
        state_q <= ST_IDLE;
        tap_q   <= '0;
      end else begin
        tap_q <= tap_q + PW'(1);
      end
    end
  end

  assign wr_ptr  = wr_q;
  assign rd_ptr  = rd_q;
  assign tap_idx = tap_q;

endmodule

// File: rtl/mac_fir_mac.sv
module mac_fir_mac #(
  parameter int SW = 16,
  parameter int CW = 16,
  parameter int AW = 37
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    en,
  input  logic                    first,
  input  logic                    last,
  input  logic signed [SW-1:0]    sample,
  input  logic signed [CW-1:0]    coef,
  output logic signed [SW+CW-1:0] prod_q,
  output logic                    prod_vld,
  output logic                    prod_first,
  output logic signed [AW-1:0]    acc,
  output logic                    out_valid,
  output logic signed [AW-1:0]    out_data
);

  localparam int PRW = SW + CW;
  localparam int XW  = AW - PRW;

  logic signed [PRW-1:0] prod_c;
  logic signed [AW-1:0]  prod_ext;
  logic                  prod_last;
  logic                  acc_done;

  assign prod_c   = sample * coef;
  assign prod_ext = {{XW{prod_q[PRW-1]}}, prod_q};

  // Stage 1: full multiply of the current operand pair.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prod_q     <= '0;
      prod_vld   <= 1'b0;
      prod_first <= 1'b0;
      prod_last  <= 1'b0;
    end else begin
      prod_vld   <= en;
      prod_first <= en && first;
      prod_last  <= en && last;
      if (en) prod_q <= prod_c;
    end
  end

  // Stage 2: accumulate, restarting on the first product of every output.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc      <= '0;
      acc_done <= 1'b0;
    end else begin
      acc_done <= prod_vld && prod_last;
      if (prod_vld) acc <= prod_first ? prod_ext : acc + prod_ext;
    end
  end

  // Stage 3: capture the completed sum.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= acc_done;
      if (acc_done) out_data <= acc;
    end
  end

endmodule

// File: rtl/mac_fir.sv
module mac_fir
  import mac_fir_pkg::*;
#(
  parameter int TAPS = 31,
  parameter int SW   = 16,
  parameter int CW   = 16
) (
  input  logic                                    clk,
  input  logic                                    rst_n,
  input  logic                                    in_valid,
  input  logic signed [SW-1:0]                    in_data,
  output logic                                    in_ready,
  output logic                                    out_valid,
  output logic signed [SW+CW+$clog2(TAPS)-1:0]    out_data
);

  localparam int PW = $clog2(TAPS);
  localparam int AW = acc_width(SW, CW, TAPS);

  logic                    accept;
  logic [PW-1:0]           wr_ptr;
  logic [PW-1:0]           rd_ptr;
  logic [PW-1:0]           tap_idx;
  logic                    mac_en;
  logic                    mac_first;
  logic                    mac_last;
  logic signed [SW-1:0]    hist_rd;
  logic signed [CW-1:0]    weight;
  logic signed [SW+CW-1:0] prod_q;
  logic                    prod_vld;
  logic                    prod_first;
  logic signed [AW-1:0]    acc;

  mac_fir_ctrl #(.TAPS(TAPS), .PW(PW)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .accept    (accept),
    .wr_ptr    (wr_ptr),
    .rd_ptr    (rd_ptr),
    .tap_idx   (tap_idx),
    .mac_en    (mac_en),
    .mac_first (mac_first),
    .mac_last  (mac_last)
  );

  mac_fir_sample_ram #(.TAPS(TAPS), .SW(SW), .PW(PW)) u_ram (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (accept),
    .waddr (wr_ptr),
    .wdata (in_data),
    .raddr (rd_ptr),
    .rdata (hist_rd)
  );

  mac_fir_coef_rom #(.TAPS(TAPS), .CW(CW), .PW(PW)) u_rom (
    .addr (tap_idx),
    .coef (weight)
  );

  mac_fir_mac #(.SW(SW), .CW(CW), .AW(AW)) u_mac (
    .clk        (clk),
    .rst_n      (rst_n),
    .en         (mac_en),
    .first      (mac_first),
    .last       (mac_last),
    .sample     (hist_rd),
    .coef       (weight),
    .prod_q     (prod_q),
    .prod_vld   (prod_vld),
    .prod_first (prod_first),
    .acc        (acc),
    .out_valid  (out_valid),
    .out_data   (out_data)
  );

endmodule

// File: rtl/mac_fir_chk.sv
module mac_fir_chk #(
  parameter int TAPS = 31,
  parameter int SW   = 16,
  parameter int CW   = 16,
  parameter int AW   = 37,
  parameter int PW   = 5
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    in_ready,
  input logic                    out_valid,
  input logic signed [AW-1:0]    out_data,
  input logic                    accept,
  input logic                    busy,
  input logic                    first_cyc,
  input logic                    last_cyc,
  input logic [PW-1:0]           wr_ptr,
  input logic [PW-1:0]           rd_ptr,
  input logic                    prod_vld,
  input logic                    prod_first,
  input logic signed [SW+CW-1:0] prod_q,
  input logic signed [AW-1:0]    acc
);

  localparam logic [PW-1:0] TOP = PW'(TAPS - 1);

  AST_READY_LOW_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !last_cyc) |-> !in_ready); // R5

  AST_ACCEPT_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> first_cyc); // R5

  AST_OUT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid); // R4

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> $stable(out_data)); // R6

  AST_WR_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (wr_ptr == (($past(wr_ptr) == TOP) ? '0 : $past(wr_ptr) + PW'(1)))); // R7

  AST_RD_BACKWARD: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !first_cyc) |-> (rd_ptr == (($past(rd_ptr) == '0) ? TOP : $past(rd_ptr) - PW'(1)))); // R7

  AST_ACC_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    (prod_vld && prod_first) |=> (acc == $past(prod_q))); // R2

endmodule

bind mac_fir mac_fir_chk #(
  .TAPS(TAPS), .SW(SW), .CW(CW), .AW(AW), .PW(PW)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .in_ready   (in_ready),
  .out_valid  (out_valid),
  .out_data   (out_data),
  .accept     (accept),
  .busy       (mac_en),
  .first_cyc  (mac_first),
  .last_cyc   (mac_last),
  .wr_ptr     (wr_ptr),
  .rd_ptr     (rd_ptr),
  .prod_vld   (prod_vld),
  .prod_first (prod_first),
  .prod_q     (prod_q),
  .acc        (acc)
);

// File: tb/mac_fir_tb.sv
module mac_fir_tb;

  localparam int TAPS = 31;
  localparam int SW   = 16;
  localparam int CW   = 16;
  localparam int AW   = SW + CW + $clog2(TAPS);

  logic                 clk = 1'b0;
  logic                 rst_n = 1'b0;
  logic                 in_valid = 1'b0;
  logic signed [SW-1:0] in_data = '0;
  logic                 in_ready;
  logic                 out_valid;
  logic signed [AW-1:0] out_data;

  always #5 clk = ~clk;

  mac_fir #(.TAPS(TAPS), .SW(SW), .CW(CW)) u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_data   (in_data),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .out_data  (out_data)
  );

  int     checks = 0;
  int     fails = 0;
  int     cyc = 0;
  int     last_acc = -100000;
  int     b2b_cnt = 0;
  bit     b2b = 1'b0;
  string  phase = "R2 start";
  longint hist [TAPS];
  longint exp_v [$];
  int     exp_t [$];
  longint prev_out = 0;

  task automatic chk(input bit ok, input string req, input longint act, input longint expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  // R8 weight rule, evaluated directly from the requirement.
  function automatic longint bench_w(input int j);
    longint m;
    longint c;
    m = 64'd65536 - 15;
    c = 64'd32768 - 8;
    return ((longint'(j) * 2731 + 97) % m) - c;
  endfunction

  function automatic longint model_out();
    longint s = 0;
    for (int j = 0; j < TAPS; j++) s += bench_w(j) * hist[j];
    return s;
  endfunction

  initial begin
    for (int j = 0; j < TAPS; j++) hist[j] = 0;
  end

  // Record accepts at the edge; expected results come from the bench model.
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (rst_n && in_valid && in_ready) begin
      for (int j = TAPS - 1; j > 0; j--) hist[j] = hist[j-1];
      hist[0] = longint'(in_data);
      exp_v.push_back(model_out());
      exp_t.push_back(cyc + 1);
      if (b2b) begin
        if (b2b_cnt > 0) chk((cyc + 1 - last_acc) == TAPS, "R5 accept spacing", cyc + 1 - last_acc, TAPS);
        b2b_cnt++;
      end
      last_acc <= cyc + 1;
    end
  end

  // Output monitor, sampled away from the active edge.
  always @(negedge clk) begin
    if (rst_n) begin
      chk(in_ready == ((cyc - last_acc) >= TAPS - 1), "R5 in_ready", in_ready, (cyc - last_acc) >= TAPS - 1);
      if (out_valid) begin
        if (exp_v.size() == 0) begin
          chk(1'b0, "R4 unexpected out_valid", 1, 0);
        end else begin
          longint e;
          int     t;
          e = exp_v.pop_front();
          t = exp_t.pop_front();
          chk(longint'(out_data) == e, $sformatf("R2 value (%s)", phase), longint'(out_data), e);
          chk((cyc - t) == TAPS + 2, "R4 latency", cyc - t, TAPS + 2);
        end
        prev_out = longint'(out_data);
      end else begin
        chk(longint'(out_data) == prev_out, "R6 hold", longint'(out_data), prev_out);
      end
    end
  end

  task automatic send(input logic [SW-1:0] x, input int gap);
    repeat (gap) @(negedge clk);
    while (!in_ready) @(negedge clk);
    in_valid = 1'b1;
    in_data  = x;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic drain();
    while (exp_v.size() != 0) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  initial begin
    void'($urandom(32'h5EED_1234));
    repeat (3) @(negedge clk);
    chk(in_ready == 1'b1, "R1 in_ready in reset", in_ready, 1);
    chk(out_valid == 1'b0, "R1 out_valid in reset", out_valid, 0);
    chk(out_data == '0, "R1 out_data in reset", longint'(out_data), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(in_ready == 1'b1, "R1 in_ready after reset", in_ready, 1);
    chk(out_valid == 1'b0, "R1 out_valid after reset", out_valid, 0);

    // R8 impulse after reset: outputs walk the weight table.
    phase = "R8 impulse";
    send(SW'(1), 0);
    for (int k = 1; k < TAPS; k++) send('0, k % 3);
    drain();

    // R7 random stream longer than the window, random idle gaps.
    phase = "R7 random";
    for (int k = 0; k < 45; k++) send(SW'($urandom), $urandom_range(0, 3));
    drain();

    // R5 back-to-back with in_valid held high whenever allowed.
    phase = "R5 back-to-back";
    b2b = 1'b1;
    for (int k = 0; k < 35; k++) send(SW'($urandom), 0);
    b2b = 1'b0;
    drain();

    // R3 full-scale corners.
    phase = "R3 negative full scale";
    for (int k = 0; k < TAPS; k++) send(SW'(-32768), 0);
    drain();
    phase = "R3 positive full scale";
    for (int k = 0; k < TAPS; k++) send(SW'(32767), 0);
    drain();
    phase = "R3 sign-matched";
    for (int k = 0; k < TAPS; k++)
      send((bench_w(TAPS - 1 - k) >= 0) ? SW'(32767) : SW'(-32768), 0);
    drain();
    phase = "R3 sign-opposed";
    for (int k = 0; k < TAPS; k++)
      send((bench_w(TAPS - 1 - k) >= 0) ? SW'(-32768) : SW'(32767), 0);
    drain();

    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL R4 watchdog expired actual=%0d expected=%0d", cyc, 0);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule